// File: doc/BRIEF.md
# SPI Two-Frame Register Access Master

This block lets on-chip logic read and write registers of an external SPI peripheral through a one-cycle request strobe. The peripheral selects its register in a separate step, so every access is split into two chip-select frames. The first frame carries an address-load command byte and the 16-bit register address. After a guaranteed deselect interval, the second frame carries either a write command followed by the data, or a read command followed by one discarded filler byte and then the returned data.

The requester chooses the direction, the register address, a 16-bit or 32-bit transfer width and the write data. The block raises `busy` for the whole access. It reports completion with a single-cycle `done` pulse. Read data is assembled most significant byte first and held on `rdata` until a later read replaces it. The serial side runs SPI mode 0: the clock idles low, MISO is sampled on the rising edge, and MOSI changes only while the clock is low.

Top module: `spi_regacc_master`

## Requirements
- R1: While reset is high, and afterwards until the first request, `cs_n` is 1, `sclk` is 0, `busy` is 0, `done` is 0 and `rdata` is 0.
- R2: The first frame of every access holds `cs_n` low and shifts out, MSB first on `mosi`, three bytes in this order: 0x20, then `req_addr[15:8]`, then `req_addr[7:0]`.
- R3: `cs_n` stays high for at least GAP_CYC = ceil(GAP_NS * CLK_KHZ / 1e6) clock cycles between the two frames of an access and between consecutive accesses.
- R4: For a write (`req_write`=1), the second frame sends 0x2D and then the data MSB first. With `req_wide`=1 it sends four data bytes, `req_wdata[31:24]` first. With `req_wide`=0 it sends two data bytes, `req_wdata[15:8]` then `req_wdata[7:0]`.
- R5: For a read (`req_write`=0), the second frame sends 0x6D, then one filler byte, then 2 (`req_wide`=0) or 4 (`req_wide`=1) data bytes. All bytes after the command go out on `mosi` as zero.
- R6: A read's `rdata` is built from the bytes received after the filler byte, taken as a big-endian value. A 16-bit read is zero-extended to 32 bits. The filler byte never reaches `rdata`.
- R7: SPI mode 0 is used. `sclk` is 0 whenever `cs_n` is 1. `mosi` changes only while `sclk` is 0. One `sclk` period lasts SCLK_DIV clock cycles.
- R8: `done` is a one-cycle pulse issued while `busy` is 1. `busy` is 0 only when `cs_n` is 1. `rdata` changes only in a cycle where `done` is 1 and the access is a read, so a write leaves the last read value in place.
- R9: A request presented while `busy` is 1 is ignored. It produces no frame and no `done` pulse.
- R10: Every frame contains a whole number of bytes: the count of rising `sclk` edges while `cs_n` is low is a nonzero multiple of 8, and equals 8 times the byte count given in R2, R4 or R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle request strobe, honoured only while idle |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_wide | input | 1 | 1 = 32-bit transfer, 0 = 16-bit transfer |
| req_addr | input | 16 | Register address |
| req_wdata | input | 32 | Write data (low half used for 16-bit writes) |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Last read result, zero-extended for 16-bit reads |
| sclk | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the peripheral |
| miso | input | 1 | Serial data from the peripheral |

## Verification
The hardest case to reach from the ports is a second request that arrives in the middle of an access. The bench starts a 32-bit read and then strobes a different write about forty cycles later, during the address frame. A correct design must show no extra frame, no extra completion and an unchanged outcome for the first access. The peripheral model answers every read with a distinctive filler byte of 0xA5, followed by data derived from the address it was given. A design that keeps the filler byte, or that loses the address between the two frames, therefore returns a value the scoreboard can tell apart.

// File: rtl/spi_regacc_pkg.sv
package spi_regacc_pkg;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;

  localparam logic [7:0] OP_LOAD_ADDR = 8'h20;
  localparam logic [7:0] OP_REG_WRITE = 8'h2D;
  localparam logic [7:0] OP_REG_READ  = 8'h6D;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_ADDR,
    SQ_GAP,
    SQ_DATA,
    SQ_TAIL
  } seq_state_t;

  // Deselect time in clock cycles, rounded up, never below one.
  function automatic int gap_cycles(input int ns, input int khz);
    longint prod;
    int     c;
    prod = longint'(ns) * longint'(khz);
    c    = int'((prod + 64'sd999_999) / 64'sd1_000_000);
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/spi_regacc_byte.sv
module spi_regacc_byte #(
  parameter int SCLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       byte_done,
  output logic [7:0] rx_byte
);

  localparam int DIV = (SCLK_DIV < 2) ? 2 : SCLK_DIV;
  localparam int LO  = DIV / 2;
  localparam int HI  = DIV - LO;
  localparam int CW  = $clog2(DIV + 1);

  logic          active;
  logic          sclk_q;
  logic          done_q;
  logic [2:0]    bit_cnt;
  logic [CW-1:0] div_cnt;
  logic [CW-1:0] phase_end;
  logic [7:0]    tx_sh;
  logic [7:0]    rx_sh;

  assign phase_end = sclk_q ? CW'(HI - 1) : CW'(LO - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      sclk_q  <= 1'b0;
      done_q  <= 1'b0;
      bit_cnt <= '0;
      div_cnt <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!active) begin
        if (start) begin
          active  <= 1'b1;
          tx_sh   <= tx_byte;
          bit_cnt <= '0;
          div_cnt <= '0;
          sclk_q  <= 1'b0;
        end
      end else if (div_cnt == phase_end) begin
        div_cnt <= '0;
        if (!sclk_q) begin
          // rising edge: capture the incoming bit
          sclk_q <= 1'b1;
          rx_sh  <= {rx_sh[6:0], miso};
        end else begin
          // falling edge: present the next outgoing bit
          sclk_q <= 1'b0;
          if (bit_cnt == 3'd7) begin
            active <= 1'b0;
            done_q <= 1'b1;
          end else begin
            bit_cnt <= bit_cnt + 3'd1;
            tx_sh   <= {tx_sh[6:0], 1'b0};
          end
        end
      end else begin
        div_cnt <= div_cnt + CW'(1);
      end
    end
  end

  assign sclk      = sclk_q;
  assign mosi      = tx_sh[7];
  assign byte_done = done_q;
  assign rx_byte   = rx_sh;

endmodule

// File: rtl/spi_regacc_gap.sv
module spi_regacc_gap #(
  parameter int CYCLES = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);

  localparam int LIM = (CYCLES < 1) ? 1 : CYCLES;
  localparam int CW  = $clog2(LIM + 1);

  logic [CW-1:0] cnt;

  assign expired = run && (cnt == CW'(LIM - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (!expired) begin
      cnt <= cnt + CW'(1);
    end
  end

endmodule

// File: rtl/spi_regacc_master.sv
module spi_regacc_master
  import spi_regacc_pkg::*;
#(
  parameter int CLK_KHZ  = 250_000,
  parameter int GAP_NS   = 80,
  parameter int SCLK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_wide,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              sclk,
  output logic              cs_n,
  output logic              mosi,
  input  logic              miso
);

  localparam int GAP_CYC = gap_cycles(GAP_NS, CLK_KHZ);

  seq_state_t        st;
  logic              busy_q;
  logic              done_q;
  logic              cs_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] acc;
  logic [DATA_W-1:0] wsh;
  logic [ADDR_W-1:0] ash;
  logic              wr_q;
  logic              wide_q;
  logic [2:0]        idx;
  logic [2:0]        last_idx;
  logic              start_q;
  logic [7:0]        tx_q;
  logic              byte_done;
  logic [7:0]        rx_byte;
  logic              gap_run;
  logic              gap_expired;

  spi_regacc_byte #(.SCLK_DIV(SCLK_DIV)) u_byte (
    .clk       (clk),
    .rst       (rst),
    .start     (start_q),
    .tx_byte   (tx_q),
    .miso      (miso),
    .sclk      (sclk),
    .mosi      (mosi),
    .byte_done (byte_done),
    .rx_byte   (rx_byte)
  );

  assign gap_run = (st == SQ_GAP) || (st == SQ_TAIL);

  spi_regacc_gap #(.CYCLES(GAP_CYC)) u_gap (
    .clk     (clk),
    .rst     (rst),
    .run     (gap_run),
    .expired (gap_expired)
  );

  // index of the final byte in the data frame
  always_comb begin
    if (wr_q) last_idx = wide_q ? 3'd4 : 3'd2;
    else      last_idx = wide_q ? 3'd5 : 3'd3;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= SQ_IDLE;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      cs_q    <= 1'b1;
      rdata_q <= '0;
      acc     <= '0;
      wsh     <= '0;
      ash     <= '0;
      wr_q    <= 1'b0;
      wide_q  <= 1'b0;
      idx     <= '0;
      start_q <= 1'b0;
      tx_q    <= '0;
    end else begin
      start_q <= 1'b0;
      done_q  <= 1'b0;
      unique case (st)
        SQ_IDLE: begin
          if (req_valid) begin
            wr_q    <= req_write;
            wide_q  <= req_wide;
            ash     <= req_addr;
            wsh     <= req_wide ? req_wdata : {req_wdata[15:0], 16'h0000};
            acc     <= '0;
            busy_q  <= 1'b1;
            cs_q    <= 1'b0;
            start_q <= 1'b1;
            tx_q    <= OP_LOAD_ADDR;
            idx     <= '0;
            st      <= SQ_ADDR;
          end
        end
        SQ_ADDR: begin
          if (byte_done) begin
            if (idx == 3'd2) begin
              cs_q <= 1'b1;
              st   <= SQ_GAP;
            end else begin
              idx     <= idx + 3'd1;
              tx_q    <= ash[15:8];
              ash     <= {ash[7:0], 8'h00};
              start_q <= 1'b1;
            end
          end
        end
        SQ_GAP: begin
          if (gap_expired) begin
            cs_q    <= 1'b0;
            start_q <= 1'b1;
            tx_q    <= wr_q ? OP_REG_WRITE : OP_REG_READ;
            idx     <= '0;
            st      <= SQ_DATA;
          end
        end
        SQ_DATA: begin
          if (byte_done) begin
            if (!wr_q && idx >= 3'd2) acc <= {acc[23:0], rx_byte};
            if (idx == last_idx) begin
              cs_q   <= 1'b1;
              done_q <= 1'b1;
              if (!wr_q) rdata_q <= {acc[23:0], rx_byte};
              st     <= SQ_TAIL;
            end else begin
              idx     <= idx + 3'd1;
              start_q <= 1'b1;
              tx_q    <= wr_q ? wsh[31:24] : 8'h00;
              if (wr_q) wsh <= {wsh[23:0], 8'h00};
            end
          end
        end
        SQ_TAIL: begin
          if (gap_expired) begin
            busy_q <= 1'b0;
            st     <= SQ_IDLE;
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assign busy  = busy_q;
  assign done  = done_q;
  assign cs_n  = cs_q;
  assign rdata = rdata_q;

endmodule

// File: rtl/spi_regacc_sva.sv
module spi_regacc_sva
  import spi_regacc_pkg::*;
#(
  parameter int CLK_KHZ = 250_000,
  parameter int GAP_NS  = 80
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              sclk,
  input logic              mosi,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] rdata
);

  localparam int GAP_CYC = gap_cycles(GAP_NS, CLK_KHZ);

  logic [15:0] hi_cnt;
  logic [15:0] rise_cnt;
  logic        sclk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt   <= 16'hFFFF;
      rise_cnt <= '0;
      sclk_d   <= 1'b0;
    end else begin
      sclk_d <= sclk;
      if (cs_n) begin
        if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 16'd1;
        rise_cnt <= '0;
      end else begin
        hi_cnt <= '0;
        if (sclk && !sclk_d) rise_cnt <= rise_cnt + 16'd1;
      end
    end
  end

  assert_cs_gap_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> (32'(hi_cnt) >= GAP_CYC));

  assert_sclk_idle_R7: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);

  assert_mosi_hold_R7: assert property (@(posedge clk) disable iff (rst)
    sclk |-> $stable(mosi));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_busy_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);

  assert_idle_cs_R8: assert property (@(posedge clk) disable iff (rst)
    !busy |-> cs_n);

  assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(rdata));

  assert_frame_bits_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> (rise_cnt[2:0] == 3'd0 && rise_cnt != 16'd0));

endmodule

bind spi_regacc_master spi_regacc_sva #(
  .CLK_KHZ (CLK_KHZ),
  .GAP_NS  (GAP_NS)
) u_sva (
  .clk   (clk),
  .rst   (rst),
  .cs_n  (cs_n),
  .sclk  (sclk),
  .mosi  (mosi),
  .busy  (busy),
  .done  (done),
  .rdata (rdata)
);

// File: tb/spi_regacc_master_tb.sv
`timescale 1ns/1ps
module spi_regacc_master_tb;

  localparam int CLK_KHZ  = 250_000;
  localparam int GAP_NS   = 80;
  localparam int SCLK_DIV = 4;
  localparam int GAP_CYC  = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic        req_wide = 1'b0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        busy, done, sclk, cs_n, mosi;
  logic [31:0] rdata;
  logic        miso = 1'b0;

  always #2 clk = ~clk;

  spi_regacc_master #(.CLK_KHZ(CLK_KHZ), .GAP_NS(GAP_NS), .SCLK_DIV(SCLK_DIV)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rdata(rdata), .sclk(sclk), .cs_n(cs_n),
    .mosi(mosi), .miso(miso)
  );

  typedef struct {
    bit          w;
    bit          wide;
    logic [15:0] a;
    logic [31:0] d;
    logic [31:0] r;
  } exp_t;

  exp_t        exp_q[$];
  int          checks = 0;
  int          bad = 0;
  int          n_push = 0;
  int          n_done = 0;
  logic [31:0] held = '0;

  function automatic logic [31:0] resp(input logic [15:0] a);
    return {a ^ 16'hC3A5, ~a};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // peripheral model and monitor, all sampling on the falling clock edge
  logic        pcs = 1'b1, psclk = 1'b0, pdone = 1'b0;
  bit          phase2 = 1'b0, seen_frame = 1'b0, per_done = 1'b0;
  int          cyc = 0, hi_len = 0, nbits = 0, last_rise = -1;
  logic [7:0]  cur = '0;
  logic [7:0]  fb [8];
  logic [63:0] stream = '0;
  logic [15:0] last_addr = '0;

  task automatic frame_end();
    exp_t        e;
    int          nexp;
    logic [31:0] got;
    logic [7:0]  orv;
    chk(nbits % 8 == 0 && nbits > 0, "R10", "frame bit count", nbits, 8);
    if (exp_q.size() == 0) begin
      chk(1'b0, "R9", "frame with no pending access", 1, 0);
      return;
    end
    e = exp_q[0];
    if (!phase2) begin
      chk(nbits == 24, "R10", "address frame bits", nbits, 24);
      chk(fb[0] == 8'h20, "R2", "address frame command", fb[0], 8'h20);
      chk({fb[1], fb[2]} == e.a, "R2", "address bytes", {fb[1], fb[2]}, e.a);
      last_addr = {fb[1], fb[2]};
      phase2 = 1'b1;
    end else begin
      nexp = (e.w ? 1 : 2) + (e.wide ? 4 : 2);
      chk(nbits == nexp * 8, "R10", "data frame bits", nbits, nexp * 8);
      if (e.w) begin
        chk(fb[0] == 8'h2D, "R4", "write command", fb[0], 8'h2D);
        got = e.wide ? {fb[1], fb[2], fb[3], fb[4]} : {16'h0, fb[1], fb[2]};
        chk(got == (e.wide ? e.d : {16'h0, e.d[15:0]}), "R4", "write data bytes",
            got, e.wide ? e.d : {16'h0, e.d[15:0]});
      end else begin
        chk(fb[0] == 8'h6D, "R5", "read command", fb[0], 8'h6D);
        orv = '0;
        for (int i = 1; i < nexp && i < 8; i++) orv = orv | fb[i];
        chk(orv == 8'h00, "R5", "mosi after read command", orv, 0);
      end
      phase2 = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    exp_t e;
    if (!rst) begin
      cyc++;
      if (pcs && !cs_n) begin
        if (seen_frame)
          chk(hi_len >= GAP_CYC, "R3", "deselect cycles", hi_len, GAP_CYC);
        seen_frame = 1'b1;
        nbits = 0;
        last_rise = -1;
        per_done = 1'b0;
        stream = {8'hFF, 8'hA5, resp(last_addr), 16'h0000};
        miso = stream[63];
      end
      if (cs_n) hi_len++;
      else hi_len = 0;
      if (!cs_n && sclk && !psclk) begin
        cur = {cur[6:0], mosi};
        nbits++;
        if (nbits % 8 == 0 && nbits <= 64) fb[nbits / 8 - 1] = cur;
        if (last_rise >= 0 && !per_done) begin
          chk(cyc - last_rise == SCLK_DIV, "R7", "sclk period", cyc - last_rise, SCLK_DIV);
          per_done = 1'b1;
        end
        last_rise = cyc;
      end
      if (!cs_n && !sclk && psclk) begin
        stream = {stream[62:0], 1'b0};
        miso = stream[63];
      end
      if (cs_n && sclk) chk(1'b0, "R7", "sclk high while deselected", 1, 0);
      if (!pcs && cs_n) frame_end();
      if (done) begin
        chk(!pdone, "R8", "done longer than one cycle", 1, 0);
        chk(busy, "R8", "busy at done", busy, 1);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9", "done with no pending access", 1, 0);
        end else begin
          e = exp_q.pop_front();
          chk(rdata == e.r, e.w ? "R8" : "R6", e.w ? "rdata kept over write" : "read data",
              rdata, e.r);
          n_done++;
        end
      end
      pcs = cs_n;
      psclk = sclk;
      pdone = done;
    end
  end

  task automatic do_acc(input bit w, input bit wide, input logic [15:0] a,
                        input logic [31:0] d);
    exp_t e;
    @(negedge clk);
    while (busy) @(negedge clk);
    e.w = w; e.wide = wide; e.a = a; e.d = d;
    if (w) e.r = held;
    else e.r = wide ? resp(a) : {16'h0, resp(a)[31:16]};
    if (!w) held = e.r;
    exp_q.push_back(e);
    n_push++;
    req_valid = 1'b1; req_write = w; req_wide = wide; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // strobes a request that must be ignored (R9)
  task automatic poke(input logic [15:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_wide = 1'b1; req_addr = a;
    req_wdata = 32'h5555_AAAA;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    bad++;
    $display("FAIL R8 watchdog actual=busy_stuck expected=completion");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(cs_n && !sclk && !busy && !done && rdata == 0, "R1", "state in reset",
        {cs_n, sclk, busy, done}, 4'b1000);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(cs_n && !sclk && !busy && !done && rdata == 0, "R1", "idle after reset",
        {cs_n, sclk, busy, done}, 4'b1000);

    do_acc(1'b1, 1'b0, 16'h0908, 32'h0000_02C9);   // R4 16-bit write
    do_acc(1'b1, 1'b1, 16'h2000, 32'hDEAD_BEEF);   // R4 32-bit write
    do_acc(1'b0, 1'b1, 16'h2084, 32'h0);           // R6 32-bit read
    do_acc(1'b0, 1'b0, 16'h0404, 32'h0);           // R6 16-bit read
    do_acc(1'b1, 1'b1, 16'h203C, 32'h0000_07FF);   // R8 write keeps rdata
    do_acc(1'b0, 1'b1, 16'hFFFF, 32'h0);           // R6 all-ones address
    do_acc(1'b0, 1'b0, 16'h0000, 32'h0);           // R6 zero address
    do_acc(1'b0, 1'b1, 16'h1234, 32'h0);           // R9 first access
    repeat (40) @(negedge clk);
    poke(16'hBEEF);                                // R9 ignored request
    repeat (60) @(negedge clk);
    poke(16'hCAFE);                                // R9 ignored in gap/data
    do_acc(1'b1, 1'b0, 16'h8001, 32'h1234_8001);   // R3 back-to-back
    do_acc(1'b0, 1'b0, 16'h8001, 32'h0);

    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (50) @(negedge clk);
    chk(n_done == n_push, "R9", "completed accesses", n_done, n_push);
    chk(exp_q.size() == 0, "R9", "pending accesses", exp_q.size(), 0);
    chk(rdata == held, "R8", "rdata held when idle", rdata, held);
    finish_run();
  end

endmodule